// File: doc/BRIEF.md
# Transmit Line Fault Monitor

This block watches the sensed transmit line through two digitised monitor bits, one per line polarity. A mark on either bit counts as line activity. The block counts transmit clock cycles without activity, and when the idle run reaches a set limit it pulls an active-low, open-drain fault pin low. When the pin is not faulted, it is released to high impedance.

A fault is not dropped at the first sign of activity. It stays asserted for a minimum hold time of a set number of clock periods. It is then released at that hold's end or at the next mark, whichever comes later. A mark that arrives while the hold is still running is remembered, so the release happens exactly when the hold ends. While the fault is held, the idle counter saturates and does not wrap. It restarts from zero when the fault is released.

The two outputs control the pad. `fault_drive_o` enables the pull-down and `pin_hiz_o` releases the pin. They are always complementary.

Top module: `line_fault_monitor`

## Requirements
- R1: After reset, `fault_drive_o` is 0, `pin_hiz_o` is 1 and the idle count is zero, so a fault needs a full IDLE_LIMIT idle cycles.
- R2: After IDLE_LIMIT (default 192) consecutive rising clock edges sampled with both monitor bits 0, `fault_drive_o` is 1 directly after the last of those edges.
- R3: A 1 on `mon_pos_i`, on `mon_neg_i`, or on both counts as a mark.
- R4: A mark sampled before the idle count reaches IDLE_LIMIT restarts the count from zero.
- R5: Once asserted, the fault stays asserted for at least MIN_HOLD (default 2) clock edges, even if a mark arrives on the very next edge.
- R6: A mark sampled during the hold window is remembered. The fault is released on the edge that ends the window, with no further mark needed.
- R7: If no mark arrived during the hold window, the fault is released on the first edge after the window at which a mark is sampled.
- R8: While no mark is sampled, the fault stays asserted for any length of time, because the counter saturates and never wraps.
- R9: After a release, a new fault needs another full IDLE_LIMIT idle cycles.
- R10: `pin_hiz_o` is always the inverse of `fault_drive_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_pos_i | input | 1 | Mark detected on positive monitor |
| mon_neg_i | input | 1 | Mark detected on negative monitor |
| fault_drive_o | output | 1 | 1 = pull the fault pin low |
| pin_hiz_o | output | 1 | 1 = fault pin released (high impedance) |

## Verification
The bench builds two instances fed by the same stimulus. One uses the defaults (IDLE_LIMIT 192, MIN_HOLD 2), which checks the real threshold and the two-period hold. The other uses IDLE_LIMIT 12 and MIN_HOLD 3. Its short limit makes many fault, hold and release rounds happen under random traffic. Its longer window leaves room for marks that come early, in the middle or late within the hold, and for long saturated stretches.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_FAULT = 1'b1
  } lfm_state_e;
endpackage

// File: rtl/lfm_mark_detect.sv
module lfm_mark_detect #(
  parameter int unsigned N_MON = 2
) (
  input  logic [N_MON-1:0] mon_i,
  output logic             mark_o
);
  assign mark_o = |mon_i;
endmodule

// File: rtl/lfm_idle_counter.sv
module lfm_idle_counter #(
  parameter int unsigned IDLE_LIMIT = 192,
  localparam int unsigned CW = $clog2(IDLE_LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          freeze_i,
  output logic          hit_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  // hit: this edge completes the idle run
  assign hit_o = !clear_i && !freeze_i && (cnt_q == CW'(IDLE_LIMIT - 1));
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (cnt_q < CW'(IDLE_LIMIT))   cnt_q <= cnt_q + 1'b1;
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(IDLE_LIMIT));
  a_r8_saturated_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(IDLE_LIMIT) && !clear_i) |=> cnt_q == CW'(IDLE_LIMIT));
endmodule

// File: rtl/lfm_fault_fsm.sv
module lfm_fault_fsm
  import lfm_pkg::*;
#(
  parameter int unsigned MIN_HOLD = 2,
  localparam int unsigned HW = (MIN_HOLD > 1) ? $clog2(MIN_HOLD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  input  logic limit_hit_i,
  output logic fault_o,
  output logic release_o
);
  lfm_state_e    state_q;
  logic [HW-1:0] hold_q;
  logic          pend_q;
  logic          hold_done;

  assign hold_done = (hold_q == HW'(MIN_HOLD - 1));
  assign release_o = (state_q == ST_FAULT) && hold_done && (mark_i || pend_q);
  assign fault_o   = (state_q == ST_FAULT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WATCH;
      hold_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WATCH: if (limit_hit_i) begin
          state_q <= ST_FAULT;
          hold_q  <= '0;
          pend_q  <= 1'b0;
        end
        ST_FAULT: begin
          if (release_o) begin
            state_q <= ST_WATCH;
            pend_q  <= 1'b0;
          end else begin
            if (mark_i)     pend_q <= 1'b1;
            if (!hold_done) hold_q <= hold_q + 1'b1;
          end
        end
        default: state_q <= ST_WATCH;
      endcase
    end
  end

  // R5: a release only ever ends a completed hold window
  a_r5_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $past(hold_q) == HW'(MIN_HOLD - 1));
  // R6: a remembered mark releases at the window end
  a_r6_pending_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && pend_q && hold_done) |=> !fault_o);
  a_r7_wait_for_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !pend_q && !mark_i) |=> fault_o);
endmodule

// File: rtl/line_fault_monitor.sv
module line_fault_monitor #(
  parameter int unsigned IDLE_LIMIT = 192,
  parameter int unsigned MIN_HOLD   = 2,
  localparam int unsigned CW = $clog2(IDLE_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_pos_i,
  input  logic mon_neg_i,
  output logic fault_drive_o,
  output logic pin_hiz_o
);
  logic          mark;
  logic          hit;
  logic          fault;
  logic          release_evt;
  logic          clear;
  logic [CW-1:0] cnt;

  lfm_mark_detect #(.N_MON(2)) u_mark (
    .mon_i  ({mon_neg_i, mon_pos_i}),
    .mark_o (mark)
  );

  // during a fault the count is frozen at its limit until release
  assign clear = (mark && !fault) || release_evt;

  lfm_idle_counter #(.IDLE_LIMIT(IDLE_LIMIT)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .freeze_i (fault),
    .hit_o    (hit),
    .cnt_o    (cnt)
  );

  lfm_fault_fsm #(.MIN_HOLD(MIN_HOLD)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mark_i      (mark),
    .limit_hit_i (hit),
    .fault_o     (fault),
    .release_o   (release_evt)
  );

  assign fault_drive_o = fault;
  assign pin_hiz_o     = !fault;

  a_r10_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_drive_o != pin_hiz_o);
  a_r2_rise_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_drive_o) |-> $past(cnt) == CW'(IDLE_LIMIT - 1));
  a_r4_mark_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark && !fault_drive_o) |=> cnt == '0);
  a_r9_restart_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_drive_o) |-> cnt == '0);
endmodule

// File: tb/line_fault_monitor_bench.sv
module line_fault_monitor_bench;
  localparam int unsigned LA = 192, HA = 2;
  localparam int unsigned LB = 12,  HB = 3;

  typedef struct {
    int unsigned cnt;
    bit          fault;
    int unsigned hold;
    bit          pend;
  } mdl_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos = 1'b0, neg = 1'b0;
  logic drv_a, hiz_a, drv_b, hiz_b;
  int   checks = 0, fails = 0;
  string tag = "R1";
  mdl_t ma, mb;

  always #4 clk = ~clk;

  line_fault_monitor u_line_fault_monitor (
    .clk_i(clk), .rst_ni(rst_n), .mon_pos_i(pos), .mon_neg_i(neg),
    .fault_drive_o(drv_a), .pin_hiz_o(hiz_a));

  line_fault_monitor #(.IDLE_LIMIT(LB), .MIN_HOLD(HB)) u_line_fault_monitor_b (
    .clk_i(clk), .rst_ni(rst_n), .mon_pos_i(pos), .mon_neg_i(neg),
    .fault_drive_o(drv_b), .pin_hiz_o(hiz_b));

  function automatic mdl_t step(mdl_t s, bit mark, int unsigned lim, int unsigned hld);
    mdl_t n = s;
    if (!s.fault) begin
      if (mark) n.cnt = 0;
      else if (s.cnt == lim - 1) begin
        n.fault = 1; n.cnt = lim; n.hold = 0; n.pend = 0;
      end else n.cnt = s.cnt + 1;
    end else if (s.hold >= hld - 1 && (mark || s.pend)) begin
      n.fault = 0; n.cnt = 0; n.hold = 0; n.pend = 0;
    end else begin
      if (mark) n.pend = 1;
      if (s.hold < hld - 1) n.hold = s.hold + 1;
    end
    return n;
  endfunction

  task automatic chk(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  // drive at negedge, model the coming posedge, check at the following negedge
  task automatic cyc(bit p, bit n, int cnt);
    for (int i = 0; i < cnt; i++) begin
      pos = p; neg = n;
      ma = step(ma, p | n, LA, HA);
      mb = step(mb, p | n, LB, HB);
      @(negedge clk);
      chk({tag, " A fault"}, drv_a, ma.fault);
      chk({tag, " B fault"}, drv_b, mb.fault);
      chk("R10 A pin", hiz_a, ~drv_a);
      chk("R10 B pin", hiz_b, ~drv_b);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ma = '{0, 0, 0, 0}; mb = '{0, 0, 0, 0};
    repeat (3) @(negedge clk);
    chk("R1 A fault", drv_a, 1'b0); chk("R1 A pin", hiz_a, 1'b1);
    chk("R1 B fault", drv_b, 1'b0); chk("R1 B pin", hiz_b, 1'b1);
    rst_n = 1'b1;
    // R1/R2: exactly limit minus one idle edges, then the limit
    tag = "R2"; cyc(0, 0, LA - 1);
    chk("R2 A not yet", drv_a, 1'b0);
    cyc(0, 0, 1);
    chk("R2 A at limit", drv_a, 1'b1);
    // R8: saturated hold for a long time
    tag = "R8"; cyc(0, 0, 600);
    chk("R8 A still held", drv_a, 1'b1);
    chk("R8 B still held", drv_b, 1'b1);
    // R3/R7: a mark on the negative monitor alone releases
    tag = "R3"; cyc(0, 1, 1);
    chk("R3 A released by neg", drv_a, 1'b0);
    chk("R7 B released by neg", drv_b, 1'b0);
    // R4: a mark one edge before the limit restarts the run
    tag = "R4"; cyc(0, 0, LA - 1); cyc(1, 0, 1); cyc(0, 0, LA - 1);
    chk("R4 A restarted", drv_a, 1'b0);
    // R2: now the limit is reached
    tag = "R2"; cyc(0, 0, 1);
    chk("R2 A after restart", drv_a, 1'b1);
    // R5/R6: mark right after assertion, release at window end
    tag = "R5"; cyc(1, 1, 1);
    chk("R5 A held through window", drv_a, 1'b1);
    tag = "R6"; cyc(0, 0, 1);
    chk("R6 A pending release", drv_a, 1'b0);
    // R9: full idle run needed again
    tag = "R9"; cyc(0, 0, LA - 1);
    chk("R9 A no early fault", drv_a, 1'b0);
    cyc(0, 0, 1);
    chk("R9 A fault again", drv_a, 1'b1);
    tag = "R7"; cyc(0, 0, 5); cyc(1, 0, 1);
    chk("R7 A release on late mark", drv_a, 1'b0);
    // random traffic with bursty idle gaps
    tag = "R2/R4/R5/R6/R7 random";
    void'($urandom(32'h1d5e_a3c1));
    for (int k = 0; k < 400; k++) begin
      int gap = ($urandom % 4 == 0) ? 150 + $urandom % 80 : $urandom % 20;
      cyc(0, 0, gap);
      cyc($urandom % 2, $urandom % 2 | 1'b0, 1);
      cyc($urandom % 2, $urandom % 2, 1 + $urandom % 4);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule